// File: doc/BRIEF.md
# Log-Domain AGC Loop Filter

This block closes the control loop of a digital automatic gain control for a set of channels (two by default). Each channel receives a measured signal level as a signed base-2 logarithm in steps of 1/64 of a doubling. On an update strobe, the block subtracts that level from a programmable target and forms an error. The error passes through a second-order loop filter: a leaky one-pole stage with gain K and pole P, followed by an integrator. The integrator value is the base-2 logarithm of the gain that a downstream applicator uses. That applicator is outside this block.

Updates happen only on the decimated strobe. Between strobes, every channel's state holds. A load pulse places a per-channel starting gain into the integrator and empties the pole stage. The integrator saturates between 0 and just under 16 doublings, and it is held at the limit it reaches so it does not wind up.

Top module: `agc_log_loop_filter`

## Requirements
- R1: A synchronous active-high reset clears the integrator and the pole state of every channel. The gain output reads 0 on the cycle after reset is seen.
- R2: The error is −req − meas. The target `req` is an unsigned 8-bit attenuation in units of 1/64 doubling. The measured level `meas` is 10-bit two's complement in the same units. A level above the target therefore lowers the gain.
- R3: While a channel's update strobe and load pulse are both low, its gain output and its pole state keep their values, whatever the level and configuration inputs do.
- R4: On an update, the pole state s becomes floor(P·s/256) + K·e, in units of 2^-14 doubling. The integrator g becomes g + s, using the old s. The gain output is g/64, as 4 integer and 8 fractional bits. The first update after a load therefore leaves the gain unchanged.
- R5: The integrator saturates at its maximum (gain output 4095) and stays there instead of winding up. When the pole state turns negative, the gain leaves the limit on the next update.
- R6: The integrator saturates at zero and does not wrap when the error is strongly negative.
- R7: A load pulse sets the gain output to `init` on the next cycle and clears the pole state. A load has priority over a simultaneous update strobe.
- R8: Each channel updates only from its own strobe, level and configuration. Activity on one channel leaves the other unchanged.
- R9: With K = 0 after a load, updates leave the gain output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_vld_i | input | NCH | Per-channel decimated update strobe |
| load_i | input | NCH | Per-channel initial-gain load pulse |
| pwr_log_i | input | NCH×10 | Measured level, signed, 1/64 doubling per LSB |
| req_lvl_i | input | NCH×8 | Target attenuation, 1/64 doubling per LSB |
| k_gain_i | input | NCH×8 | Loop gain K, unsigned fraction /256 |
| p_pole_i | input | NCH×8 | Pole P, unsigned fraction /256 |
| init_gain_i | input | NCH×12 | Starting gain, 4.8 log2 format |
| gain_log_o | output | NCH×12 | Gain in log2 domain, 4.8 format |

## Verification
Each strobe or load moves the registered state at the edge that samples it, so the gain output carries the result one clock later. The effect of a given error on the gain appears only on the following update, because the integrator adds the pole state it held before. The bench advances its behavioural model at each rising edge from the inputs it set half a cycle earlier. It compares every channel's gain at the next falling edge, and it places its explicit checks on the first or second update after a load, where the one-update delay is visible.

// File: rtl/agc_lf_pkg.sv
package agc_lf_pkg;
    parameter int PWR_W   = 10;
    parameter int LVL_W   = 8;
    parameter int COEF_W  = 8;
    parameter int GAIN_W  = 12;
    parameter int XFRAC_W = 6;

    localparam int ERR_W = PWR_W + 1;
    localparam int ACC_W = GAIN_W + XFRAC_W;
    localparam int KE_W  = ERR_W + COEF_W + 1;
    localparam int ST_W  = ERR_W + 2 * COEF_W + 1;
    localparam int PP_W  = ST_W + COEF_W + 1;
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } integ_act_e;

    typedef struct packed {
        logic [COEF_W-1:0] k;
        logic [COEF_W-1:0] p;
        logic [LVL_W-1:0]  req;
        logic [GAIN_W-1:0] init;
    } chan_cfg_t;

    function automatic logic signed [ERR_W-1:0] form_err(
        input logic [LVL_W-1:0]        req,
        input logic signed [PWR_W-1:0] meas
    );
        logic signed [ERR_W-1:0] r;
        logic signed [ERR_W-1:0] m;
        r = ERR_W'($signed({1'b0, req}));
        m = ERR_W'(meas);
        return -r - m;
    endfunction

    function automatic logic [ACC_W-1:0] clamp_acc(input logic signed [ST_W:0] v);
        if (v < 0)
            return '0;
        else if (v > $signed({{(ST_W + 1 - ACC_W){1'b0}}, ACC_MAX}))
            return ACC_MAX;
        else
            return v[ACC_W-1:0];
    endfunction
endpackage

// File: rtl/agc_err.sv
module agc_err
    import agc_lf_pkg::*;
(
    input  logic [LVL_W-1:0]        req_i,
    input  logic signed [PWR_W-1:0] meas_i,
    output logic signed [ERR_W-1:0] err_o
);
    assign err_o = form_err(req_i, meas_i);
endmodule

// File: rtl/agc_pole.sv
module agc_pole
    import agc_lf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr_i,
    input  logic                    step_i,
    input  logic [COEF_W-1:0]       k_i,
    input  logic [COEF_W-1:0]       p_i,
    input  logic signed [ERR_W-1:0] err_i,
    output logic signed [ST_W-1:0]  s_o
);
    logic signed [ST_W-1:0] s_q;
    logic signed [PP_W-1:0] prod_ps;
    logic signed [PP_W-1:0] prod_sh;
    logic signed [KE_W-1:0] ke;
    logic signed [ST_W-1:0] s_next;

    assign prod_ps = PP_W'(s_q) * PP_W'($signed({1'b0, p_i}));
    assign prod_sh = prod_ps >>> COEF_W;
    assign ke      = KE_W'(err_i) * KE_W'($signed({1'b0, k_i}));
    assign s_next  = ST_W'(prod_sh) + ST_W'(ke);

    always_ff @(posedge clk) begin
        if (rst)
            s_q <= '0;
        else if (clr_i)
            s_q <= '0;
        else if (step_i)
            s_q <= s_next;
    end

    assign s_o = s_q;

    // R3: no strobe and no load, pole state holds
    assert_pole_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !clr_i) |=> $stable(s_q));
    // R7: a load empties the pole stage
    assert_pole_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (s_q == '0));
endmodule

// File: rtl/agc_integ.sv
module agc_integ
    import agc_lf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  integ_act_e             act_i,
    input  logic signed [ST_W-1:0] s_i,
    input  logic [GAIN_W-1:0]      init_i,
    output logic [GAIN_W-1:0]      gain_o
);
    logic [ACC_W-1:0]     acc_q;
    logic signed [ST_W:0] sum;

    assign sum = (ST_W + 1)'($signed({1'b0, acc_q})) + (ST_W + 1)'(s_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            case (act_i)
                ACT_LOAD: acc_q <= {init_i, {XFRAC_W{1'b0}}};
                ACT_STEP: acc_q <= clamp_acc(sum);
                default:  acc_q <= acc_q;
            endcase
        end
    end

    assign gain_o = acc_q[ACC_W-1:XFRAC_W];

    // R3: no action, integrator holds
    assert_integ_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_HOLD) |=> $stable(acc_q));
    // R4/R5: a positive pole state never lowers the integrator
    assert_integ_up_R4: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_STEP && s_i > 0) |=> (acc_q >= $past(acc_q)));
    // R4/R6: a negative pole state never raises the integrator
    assert_integ_down_R4: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_STEP && s_i < 0) |=> (acc_q <= $past(acc_q)));
    // R7: a load places the starting gain on the output
    assert_integ_load_R7: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_LOAD) |=> (gain_o == $past(init_i)));
endmodule

// File: rtl/agc_log_loop_filter.sv
module agc_log_loop_filter
    import agc_lf_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NCH-1:0]                 upd_vld_i,
    input  logic [NCH-1:0]                 load_i,
    input  logic [NCH-1:0][PWR_W-1:0]      pwr_log_i,
    input  logic [NCH-1:0][LVL_W-1:0]      req_lvl_i,
    input  logic [NCH-1:0][COEF_W-1:0]     k_gain_i,
    input  logic [NCH-1:0][COEF_W-1:0]     p_pole_i,
    input  logic [NCH-1:0][GAIN_W-1:0]     init_gain_i,
    output logic [NCH-1:0][GAIN_W-1:0]     gain_log_o
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        chan_cfg_t               cfg;
        integ_act_e              act;
        logic signed [ERR_W-1:0] err;
        logic signed [ST_W-1:0]  pole_s;
        logic                    pole_step;

        assign cfg.k    = k_gain_i[ch];
        assign cfg.p    = p_pole_i[ch];
        assign cfg.req  = req_lvl_i[ch];
        assign cfg.init = init_gain_i[ch];

        always_comb begin
            if (load_i[ch])
                act = ACT_LOAD;
            else if (upd_vld_i[ch])
                act = ACT_STEP;
            else
                act = ACT_HOLD;
        end

        assign pole_step = (act == ACT_STEP);

        agc_err u_err (
            .req_i  (cfg.req),
            .meas_i ($signed(pwr_log_i[ch])),
            .err_o  (err)
        );

        agc_pole u_pole (
            .clk    (clk),
            .rst    (rst),
            .clr_i  (load_i[ch]),
            .step_i (pole_step),
            .k_i    (cfg.k),
            .p_i    (cfg.p),
            .err_i  (err),
            .s_o    (pole_s)
        );

        agc_integ u_integ (
            .clk    (clk),
            .rst    (rst),
            .act_i  (act),
            .s_i    (pole_s),
            .init_i (cfg.init),
            .gain_o (gain_log_o[ch])
        );

        // R8: a quiet channel keeps its gain regardless of the others
        assert_chan_quiet_R8: assert property (@(posedge clk) disable iff (rst)
            (!upd_vld_i[ch] && !load_i[ch]) |=> $stable(gain_log_o[ch]));
    end

    // R1: reset leaves every gain at zero
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (gain_log_o == '0));
endmodule

// File: tb/tb_agc_log_loop_filter.sv
module tb_agc_log_loop_filter;
    localparam int NCH = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                  rst;
    logic [NCH-1:0]        vld, ld;
    logic [NCH-1:0][9:0]   pwr;
    logic [NCH-1:0][7:0]   req, kk, pp;
    logic [NCH-1:0][11:0]  init;
    logic [NCH-1:0][11:0]  gain;

    agc_log_loop_filter #(.NCH(NCH)) dut (
        .clk(clk), .rst(rst), .upd_vld_i(vld), .load_i(ld),
        .pwr_log_i(pwr), .req_lvl_i(req), .k_gain_i(kk), .p_pole_i(pp),
        .init_gain_i(init), .gain_log_o(gain)
    );

    longint m_s [NCH];
    longint m_g [NCH];
    int     checks = 0;
    int     errors = 0;
    string  tag = "R1";
    bit     done = 1'b0;
    int unsigned lcg = 32'h1234_5678;

    task automatic chk(input string rq, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin m_s[c] = 0; m_g[c] = 0; end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (ld[c]) begin
                    m_g[c] = longint'(init[c]) * 64;
                    m_s[c] = 0;
                end else if (vld[c]) begin
                    longint e, gn, sn;
                    e  = -longint'(req[c]) - longint'($signed(pwr[c]));
                    gn = m_g[c] + m_s[c];
                    if (gn < 0) gn = 0;
                    if (gn > 262143) gn = 262143;
                    sn = ((longint'(pp[c]) * m_s[c]) >>> 8) + longint'(kk[c]) * e;
                    m_g[c] = gn;
                    m_s[c] = sn;
                end
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            checks++;
            if (longint'(gain[c]) != (m_g[c] >>> 6)) begin
                errors++;
                $display("FAIL %s ch%0d gain actual=%0d expected=%0d",
                         tag, c, gain[c], m_g[c] >>> 6);
            end
        end
    endtask

    task automatic run(input int n, input int period, input logic [NCH-1:0] en,
                       input int base0, input int base1, input bit vary);
        for (int i = 0; i < n; i++) begin
            vld = ((i % period) == period - 1) ? en : '0;
            if (vary) begin
                lcg = lcg * 1103515245 + 12345;
                pwr[0] = 10'(base0 + int'(lcg[20:15]) - 32);
                pwr[1] = 10'(base1 + int'(lcg[26:21]) - 32);
            end
            step();
        end
        vld = '0;
    endtask

    task automatic load(input logic [NCH-1:0] which);
        ld = which;
        step();
        ld = '0;
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; vld = '0; ld = '0; pwr = '0; req = '0; kk = '0; pp = '0; init = '0;
        for (int c = 0; c < NCH; c++) begin m_s[c] = 0; m_g[c] = 0; end
        tag = "R1";
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1", gain[0], 0);
        chk("R1", gain[1], 0);

        // R7: load places the starting gain
        tag = "R7";
        init[0] = 12'h800; init[1] = 12'h3C0;
        load(2'b11);
        chk("R7", gain[0], 12'h800);
        chk("R7", gain[1], 12'h3C0);

        // R3: inputs move but no strobe
        tag = "R3";
        kk = {8'd90, 8'd90}; pp = {8'd50, 8'd50}; req = {8'd10, 8'd30};
        pwr[0] = 10'(-300); pwr[1] = 10'(200);
        repeat (6) step();
        chk("R3", gain[0], 12'h800);
        chk("R3", gain[1], 12'h3C0);

        // R4: one-update delay and first increment
        tag = "R4";
        kk[0] = 8'd64; pp[0] = 8'd128; req[0] = 8'd64; pwr[0] = 10'(-200);
        init[0] = 12'h500;
        load(2'b01);
        vld = 2'b01; step();
        chk("R4", gain[0], 12'h500);
        step(); vld = '0;
        chk("R4", gain[0], 1280 + 136);

        // R2: level above target lowers the gain
        tag = "R2";
        kk[0] = 8'd64; pp[0] = 8'd0; req[0] = 8'd0; pwr[0] = 10'd64;
        load(2'b01);
        vld = 2'b01; step();
        chk("R2", gain[0], 1280);
        step(); vld = '0;
        chk("R2", gain[0], 1216);

        // R4 and R2: both channels, decimated strobes, varying levels
        tag = "R4";
        kk = {8'd32, 8'd64}; pp = {8'd240, 8'd128}; req = {8'd20, 8'd64};
        init = {12'h400, 12'h600};
        load(2'b11);
        run(120, 4, 2'b11, -200, -100, 1'b1);

        // R8: only channel B updates
        tag = "R8";
        begin
            logic [11:0] a_before;
            a_before = gain[0];
            run(40, 3, 2'b10, 300, -250, 1'b1);
            chk("R8", gain[0], a_before);
        end

        // R5: drive to the upper limit, then recover without windup
        tag = "R5";
        kk[0] = 8'd255; pp[0] = 8'd200; req[0] = 8'd0; pwr[0] = 10'h200;
        init[0] = 12'h800;
        load(2'b01);
        run(200, 1, 2'b01, 0, 0, 1'b0);
        chk("R5", gain[0], 4095);
        pwr[0] = 10'd511;
        run(10, 1, 2'b01, 0, 0, 1'b0);
        chk("R5", (gain[0] < 12'd4095) ? 1 : 0, 1);

        // R6: drive to zero
        tag = "R6";
        kk[0] = 8'd255; pp[0] = 8'd0; req[0] = 8'd0; pwr[0] = 10'd511;
        init[0] = 12'h010;
        load(2'b01);
        run(20, 1, 2'b01, 0, 0, 1'b0);
        chk("R6", gain[0], 0);

        // R9: zero loop gain freezes the output
        tag = "R9";
        kk[0] = 8'd0; pp[0] = 8'd100; pwr[0] = 10'(-400);
        init[0] = 12'h300;
        load(2'b01);
        run(10, 1, 2'b01, 0, 0, 1'b0);
        chk("R9", gain[0], 12'h300);

        // R7: load beats a simultaneous strobe and clears the pole stage
        tag = "R7";
        kk[0] = 8'd200; pp[0] = 8'd100; pwr[0] = 10'(-300); req[0] = 8'd0;
        run(5, 1, 2'b01, 0, 0, 1'b0);
        init[0] = 12'h123;
        ld = 2'b01; vld = 2'b01; step(); ld = '0;
        chk("R7", gain[0], 12'h123);
        step(); vld = '0;
        chk("R7", gain[0], 12'h123);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule